// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register store of a 32-bit processor core. A single combinational read port and a single write port select registers through a 6-bit index. Fifteen general registers sit at indices 1 to 15. Index 0 is an alias for the stack pointer. The alias is steered by the user bit of the status word, so the same index reaches either the user stack pointer or the interrupt stack pointer.

Control state also lives here:
- the status word;
- the program counter;
- a backup program counter and a backup status word;
- an interrupt vector base and a fast-interrupt vector;
- a floating-point status word with special write rules;
- a 64-bit accumulator.

The accumulator is reached in whole through a dedicated 64-bit port. It can also be reached through three overlapping 32-bit windows on the normal ports: high, middle and low.

Reads always see the state as it will be after the current cycle's writes. A reader therefore never waits a cycle for a value written in the same cycle. Indices with no register behind them read as zero and raise a strobe that decode logic can turn into an exception.

Top module: `bank_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero, including the accumulator and the FP status word. `user_mode` and `round_mode` then read 0.
- R2: Write indices 1 to 15 reach fifteen independent 32-bit general registers. A read of the same index returns the value written.
- R3: Index 0 reaches the user stack pointer (index 18) when status bit 17 is 1, and the interrupt stack pointer (index 19) when it is 0, for both reads and writes. `user_mode` shows status bit 17.
- R4: These indices each hold a plain 32-bit register that reads back what was written:
  - 16: status word
  - 17: program counter
  - 18: user stack pointer
  - 19: interrupt stack pointer
  - 21: backup program counter
  - 22: backup status word
  - 23: vector base
  - 24: fast vector
- R5: Index 25 reads accumulator bits 63:32. A write there replaces those bits and keeps bits 31:0.
- R6: Index 26 reads accumulator bits 47:16. A write there replaces exactly bits 47:16 and keeps bits 63:48 and 15:0.
- R7: Index 27 reads accumulator bits 31:0. A write there replaces those bits and keeps bits 63:32.
- R8: `acc_wr_en` replaces all 64 accumulator bits with `acc_wr_data`, and `acc_rd_data` shows the whole accumulator. When the full port and a window write hit in the same cycle, the full port wins.
- R9: A write to index 20 (FP status) behaves as follows:
  - Each cause bit 7:2 becomes the AND of its old value and the written bit, so a write can clear a cause bit but never set one.
  - Bits 30:8 and 1:0 take the written value.
  - `fp_cause_set` bit n sets cause bit n+2 in any cycle.
- R10: After every FP status write, bit 31 is 1 exactly when any of bits 12:8 is 1, whatever was written to bit 31.
- R11: `round_mode` shows FP status bits 1:0, with this encoding:
  - 0: round to nearest
  - 1: round toward zero
  - 2: round toward +infinity
  - 3: round toward -infinity
- R12: Indices 28 to 63 read zero with `rd_illegal` high, and `rd_illegal` is low for indices 0 to 27. Writes to indices 28 to 63 change no register.
- R13: A read in the same cycle as a write returns the state as it will be after that edge. This includes the index-0 alias following a same-cycle status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | 6 | Read index |
| rd_data | output | 32 | Read data, combinational, bypassed |
| rd_illegal | output | 1 | Read index has no register behind it |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write index |
| wr_data | input | 32 | Write data |
| acc_wr_en | input | 1 | Whole-accumulator write strobe |
| acc_wr_data | input | 64 | Whole-accumulator write data |
| acc_rd_data | output | 64 | Whole accumulator, bypassed |
| fp_cause_set | input | 6 | Hardware raise of FP cause bits 7:2 |
| round_mode | output | 2 | Committed FP rounding mode |
| user_mode | output | 1 | Committed status bit 17 |

## Verification
The assertions rely on the following conditions, which the stimulus respects:
- `rst` is high from time zero.
- Only one register is written through the index port per cycle.
- The accumulator window assertions assume the full 64-bit port is idle in that cycle.
- The cause-bit assertion assumes `fp_cause_set` is zero during an FP status write.

The stimulus drives every input on the falling edge and holds it for exactly one cycle. It combines the full port with a window write only in the dedicated priority case. It raises cause bits only in cycles that carry no FP status write. Read checks sample one time unit after the falling edge, while no write is pending, except in the bypass cases, which deliberately sample during the write cycle.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  localparam int DW       = 32;
  localparam int ACC_W    = 64;
  localparam int NUM_GPR  = 15;
  localparam int GSEL_W   = $clog2(NUM_GPR + 1);

  // index map (index 0 and 1..NUM_GPR are fixed by function)
  localparam int IX_STAT  = 16;
  localparam int IX_PC    = 17;
  localparam int IX_USP   = 18;
  localparam int IX_ISP   = 19;
  localparam int IX_FPST  = 20;
  localparam int IX_BKPC  = 21;
  localparam int IX_BKST  = 22;
  localparam int IX_VBASE = 23;
  localparam int IX_FVEC  = 24;
  localparam int IX_ACCH  = 25;
  localparam int IX_ACCM  = 26;
  localparam int IX_ACCL  = 27;

  localparam int USER_BIT  = 17;
  localparam int RM_W      = 2;
  localparam int CAUSE_LSB = 2;
  localparam int CAUSE_W   = 6;
  localparam int FLAG_LSB  = 8;
  localparam int FLAG_W    = 5;
  localparam int SUM_BIT   = 31;
  localparam int MID_LSB   = 16;

  localparam logic [DW-1:0] CAUSE_MASK = ((DW'(1) << CAUSE_W) - DW'(1)) << CAUSE_LSB;
  localparam logic [DW-1:0] FLAG_MASK  = ((DW'(1) << FLAG_W) - DW'(1)) << FLAG_LSB;

  typedef enum logic [3:0] {
    K_NONE, K_SP, K_GPR, K_STAT, K_PC, K_USP, K_ISP, K_FPST,
    K_BKPC, K_BKST, K_VBASE, K_FVEC, K_ACCH, K_ACCM, K_ACCL
  } reg_kind_e;

  typedef enum logic [RM_W-1:0] {
    RND_NEAREST, RND_ZERO, RND_POS_INF, RND_NEG_INF
  } rnd_mode_e;

  // merge a 32-bit window write into the accumulator
  function automatic logic [ACC_W-1:0] acc_window_put(
    input logic [ACC_W-1:0] acc, input reg_kind_e k, input logic [DW-1:0] v);
    logic [ACC_W-1:0] keep;
    logic [ACC_W-1:0] ins;
    int               lsb;
    case (k)
      K_ACCH:  lsb = ACC_W - DW;
      K_ACCM:  lsb = MID_LSB;
      default: lsb = 0;
    endcase
    keep = ~(ACC_W'({DW{1'b1}}) << lsb);
    ins  = ACC_W'(v) << lsb;
    if (k == K_ACCH || k == K_ACCM || k == K_ACCL)
      return (acc & keep) | ins;
    return acc;
  endfunction

  function automatic logic [DW-1:0] acc_window_get(
    input logic [ACC_W-1:0] acc, input reg_kind_e k);
    case (k)
      K_ACCH:  return acc[ACC_W-1 -: DW];
      K_ACCM:  return acc[MID_LSB +: DW];
      K_ACCL:  return acc[DW-1:0];
      default: return '0;
    endcase
  endfunction

  // FP status update: AND-only cause bits, recomputed summary, hardware raise
  function automatic logic [DW-1:0] fpst_next(
    input logic [DW-1:0] old, input logic [DW-1:0] wdata, input logic we,
    input logic [CAUSE_W-1:0] raise);
    logic [DW-1:0] n;
    n = old;
    if (we) begin
      n = (wdata & ~CAUSE_MASK) | (old & wdata & CAUSE_MASK);
      n[SUM_BIT] = |(n & FLAG_MASK);
    end
    n = n | (DW'(raise) << CAUSE_LSB);
    return n;
  endfunction

endpackage

// File: rtl/bank_rf_decode.sv
module bank_rf_decode
  import bank_rf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output reg_kind_e        kind
);

  always_comb begin
    kind = K_NONE;
    if (idx == '0) begin
      kind = K_SP;
    end else if (idx <= IDX_W'(NUM_GPR)) begin
      kind = K_GPR;
    end else begin
      case (idx)
        IDX_W'(IX_STAT):  kind = K_STAT;
        IDX_W'(IX_PC):    kind = K_PC;
        IDX_W'(IX_USP):   kind = K_USP;
        IDX_W'(IX_ISP):   kind = K_ISP;
        IDX_W'(IX_FPST):  kind = K_FPST;
        IDX_W'(IX_BKPC):  kind = K_BKPC;
        IDX_W'(IX_BKST):  kind = K_BKST;
        IDX_W'(IX_VBASE): kind = K_VBASE;
        IDX_W'(IX_FVEC):  kind = K_FVEC;
        IDX_W'(IX_ACCH):  kind = K_ACCH;
        IDX_W'(IX_ACCM):  kind = K_ACCM;
        IDX_W'(IX_ACCL):  kind = K_ACCL;
        default:          kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bank_rf_gpr.sv
module bank_rf_gpr
  import bank_rf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [GSEL_W-1:0]          widx,
  input  logic [DW-1:0]              wdata,
  output logic [NUM_GPR:0][DW-1:0]   nxt
);

  assign nxt[0] = '0;

  for (genvar g = 1; g <= NUM_GPR; g++) begin : g_reg
    logic [DW-1:0] q;
    assign nxt[g] = (we && widx == GSEL_W'(g)) ? wdata : q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt[g];
    end
  end

endmodule

// File: rtl/bank_rf_acc.sv
module bank_rf_acc
  import bank_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             win_we,
  input  reg_kind_e        win_kind,
  input  logic [DW-1:0]    win_data,
  input  logic             full_we,
  input  logic [ACC_W-1:0] full_data,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] acc_nxt
);

  always_comb begin
    acc_nxt = acc_q;
    if (full_we)     acc_nxt = full_data;
    else if (win_we) acc_nxt = acc_window_put(acc_q, win_kind, win_data);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_nxt;
  end

endmodule

// File: rtl/bank_rf_fpst.sv
module bank_rf_fpst
  import bank_rf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [DW-1:0]      wdata,
  input  logic [CAUSE_W-1:0] raise,
  output logic [DW-1:0]      fpst_q,
  output logic [DW-1:0]      fpst_nxt,
  output logic [RM_W-1:0]    round_mode
);

  assign fpst_nxt   = fpst_next(fpst_q, wdata, we, raise);
  assign round_mode = fpst_q[RM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) fpst_q <= '0;
    else     fpst_q <= fpst_nxt;
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic                rd_illegal,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                acc_wr_en,
  input  logic [ACC_W-1:0]    acc_wr_data,
  output logic [ACC_W-1:0]    acc_rd_data,
  input  logic [CAUSE_W-1:0]  fp_cause_set,
  output logic [RM_W-1:0]     round_mode,
  output logic                user_mode
);

  reg_kind_e rk, wk;

  bank_rf_decode #(.IDX_W(IDX_W)) u_rdec (.idx(rd_idx), .kind(rk));
  bank_rf_decode #(.IDX_W(IDX_W)) u_wdec (.idx(wr_idx), .kind(wk));

  // named write events
  logic ev_sp_wr, ev_gpr_wr, ev_fpst_wr, ev_acc_win_wr;
  logic ev_acc_hi_wr, ev_acc_mid_wr, ev_acc_lo_wr;
  assign ev_sp_wr      = wr_en && (wk == K_SP);
  assign ev_gpr_wr     = wr_en && (wk == K_GPR);
  assign ev_fpst_wr    = wr_en && (wk == K_FPST);
  assign ev_acc_hi_wr  = wr_en && (wk == K_ACCH);
  assign ev_acc_mid_wr = wr_en && (wk == K_ACCM);
  assign ev_acc_lo_wr  = wr_en && (wk == K_ACCL);
  assign ev_acc_win_wr = ev_acc_hi_wr | ev_acc_mid_wr | ev_acc_lo_wr;

  // general registers
  logic [NUM_GPR:0][DW-1:0] gpr_nxt;
  bank_rf_gpr u_gpr (
    .clk(clk), .rst(rst), .we(ev_gpr_wr),
    .widx(wr_idx[GSEL_W-1:0]), .wdata(wr_data), .nxt(gpr_nxt)
  );

  // accumulator
  logic [ACC_W-1:0] acc_q, acc_nxt;
  bank_rf_acc u_acc (
    .clk(clk), .rst(rst), .win_we(ev_acc_win_wr), .win_kind(wk),
    .win_data(wr_data), .full_we(acc_wr_en), .full_data(acc_wr_data),
    .acc_q(acc_q), .acc_nxt(acc_nxt)
  );

  // FP status
  logic [DW-1:0] fpst_q, fpst_nxt;
  bank_rf_fpst u_fpst (
    .clk(clk), .rst(rst), .we(ev_fpst_wr), .wdata(wr_data),
    .raise(fp_cause_set), .fpst_q(fpst_q), .fpst_nxt(fpst_nxt),
    .round_mode(round_mode)
  );

  // plain control registers and banked stack pointers
  logic [DW-1:0] stat_q, pc_q, usp_q, isp_q, bkpc_q, bkst_q, vbase_q, fvec_q;
  logic [DW-1:0] stat_n, pc_n, usp_n, isp_n, bkpc_n, bkst_n, vbase_n, fvec_n;
  logic          stat_user_q;

  assign stat_user_q = stat_q[USER_BIT];

  always_comb begin
    stat_n  = stat_q;
    pc_n    = pc_q;
    usp_n   = usp_q;
    isp_n   = isp_q;
    bkpc_n  = bkpc_q;
    bkst_n  = bkst_q;
    vbase_n = vbase_q;
    fvec_n  = fvec_q;
    if (wr_en) begin
      case (wk)
        K_SP:    if (stat_user_q) usp_n = wr_data; else isp_n = wr_data;
        K_STAT:  stat_n  = wr_data;
        K_PC:    pc_n    = wr_data;
        K_USP:   usp_n   = wr_data;
        K_ISP:   isp_n   = wr_data;
        K_BKPC:  bkpc_n  = wr_data;
        K_BKST:  bkst_n  = wr_data;
        K_VBASE: vbase_n = wr_data;
        K_FVEC:  fvec_n  = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      pc_q    <= '0;
      usp_q   <= '0;
      isp_q   <= '0;
      bkpc_q  <= '0;
      bkst_q  <= '0;
      vbase_q <= '0;
      fvec_q  <= '0;
    end else begin
      stat_q  <= stat_n;
      pc_q    <= pc_n;
      usp_q   <= usp_n;
      isp_q   <= isp_n;
      bkpc_q  <= bkpc_n;
      bkst_q  <= bkst_n;
      vbase_q <= vbase_n;
      fvec_q  <= fvec_n;
    end
  end

  // read port: every source is the next-state value (write bypass)
  always_comb begin
    case (rk)
      K_SP:    rd_data = stat_n[USER_BIT] ? usp_n : isp_n;
      K_GPR:   rd_data = gpr_nxt[rd_idx[GSEL_W-1:0]];
      K_STAT:  rd_data = stat_n;
      K_PC:    rd_data = pc_n;
      K_USP:   rd_data = usp_n;
      K_ISP:   rd_data = isp_n;
      K_FPST:  rd_data = fpst_nxt;
      K_BKPC:  rd_data = bkpc_n;
      K_BKST:  rd_data = bkst_n;
      K_VBASE: rd_data = vbase_n;
      K_FVEC:  rd_data = fvec_n;
      K_ACCH, K_ACCM, K_ACCL: rd_data = acc_window_get(acc_nxt, rk);
      default: rd_data = '0;
    endcase
  end

  assign rd_illegal  = (rk == K_NONE);
  assign acc_rd_data = acc_nxt;
  assign user_mode   = stat_user_q;

endmodule

// File: rtl/bank_rf_chk.sv
module bank_rf_chk
  import bank_rf_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               rd_illegal,
  input logic [DW-1:0]      rd_data,
  input logic               acc_wr_en,
  input logic [ACC_W-1:0]   acc_wr_data,
  input logic [CAUSE_W-1:0] fp_cause_set,
  input logic               ev_sp_wr,
  input logic               ev_fpst_wr,
  input logic               ev_acc_hi_wr,
  input logic               ev_acc_mid_wr,
  input logic               ev_acc_lo_wr,
  input logic               stat_user_q,
  input logic [DW-1:0]      usp_q,
  input logic [DW-1:0]      isp_q,
  input logic [DW-1:0]      fpst_q,
  input logic [ACC_W-1:0]   acc_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && fpst_q == '0 && usp_q == '0 && isp_q == '0)); // R1

  AST_SP_KERNEL_SIDE: assert property (@(posedge clk) disable iff (rst)
    ev_sp_wr && !stat_user_q |=> $stable(usp_q)); // R3

  AST_SP_USER_SIDE: assert property (@(posedge clk) disable iff (rst)
    ev_sp_wr && stat_user_q |=> $stable(isp_q)); // R3

  AST_ACC_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    ev_acc_hi_wr && !acc_wr_en |=> $stable(acc_q[DW-1:0])); // R5

  AST_ACC_MID_KEEPS_EDGES: assert property (@(posedge clk) disable iff (rst)
    ev_acc_mid_wr && !acc_wr_en |=>
      ($stable(acc_q[ACC_W-1:MID_LSB+DW]) && $stable(acc_q[MID_LSB-1:0]))); // R6

  AST_ACC_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    ev_acc_lo_wr && !acc_wr_en |=> $stable(acc_q[ACC_W-1:DW])); // R7

  AST_FULL_ACC_WINS: assert property (@(posedge clk) disable iff (rst)
    acc_wr_en |=> acc_q == $past(acc_wr_data)); // R8

  AST_CAUSE_NEVER_SW_SET: assert property (@(posedge clk) disable iff (rst)
    ev_fpst_wr && fp_cause_set == '0 |=>
      ((fpst_q & CAUSE_MASK) & ~$past(fpst_q & CAUSE_MASK)) == '0); // R9

  AST_SUMMARY_MATCHES: assert property (@(posedge clk) disable iff (rst)
    ev_fpst_wr |=> fpst_q[SUM_BIT] == |(fpst_q & FLAG_MASK)); // R10

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_illegal |-> rd_data == '0); // R12

endmodule

bind bank_regfile bank_rf_chk u_chk (
  .clk(clk), .rst(rst), .rd_illegal(rd_illegal), .rd_data(rd_data),
  .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
  .fp_cause_set(fp_cause_set), .ev_sp_wr(ev_sp_wr), .ev_fpst_wr(ev_fpst_wr),
  .ev_acc_hi_wr(ev_acc_hi_wr), .ev_acc_mid_wr(ev_acc_mid_wr),
  .ev_acc_lo_wr(ev_acc_lo_wr), .stat_user_q(stat_user_q),
  .usp_q(usp_q), .isp_q(isp_q), .fpst_q(fpst_q), .acc_q(acc_q)
);

// File: tb/bank_regfile_test.sv
module bank_regfile_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int N_IDX      = 1 << IDX_W;
  localparam int LAST_LEGAL = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        rd_illegal;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        acc_wr_en = 1'b0;
  logic [63:0] acc_wr_data = '0;
  logic [63:0] acc_rd_data;
  logic [5:0]  fp_cause_set = '0;
  logic [1:0]  round_mode;
  logic        user_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_regfile #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_illegal(rd_illegal), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .acc_rd_data(acc_rd_data), .fp_cause_set(fp_cause_set),
    .round_mode(round_mode), .user_mode(user_mode)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // reference model, written from the requirements
  logic [31:0] m_gpr [1:15];
  logic [31:0] m_stat, m_pc, m_usp, m_isp, m_fpst, m_bkpc, m_bkst, m_vbase, m_fvec;
  logic [63:0] m_acc;

  function automatic logic [31:0] fp_model(logic [31:0] old, logic [31:0] v);
    logic [31:0] n;
    for (int b = 0; b < 32; b++) begin
      if (b >= 2 && b <= 7) n[b] = old[b] & v[b];
      else                  n[b] = v[b];
    end
    n[31] = (n[12:8] != 5'd0);
    return n;
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    if (i >= 1 && i <= 15) return m_gpr[i];
    case (i)
      0:  return m_stat[17] ? m_usp : m_isp;
      16: return m_stat;
      17: return m_pc;
      18: return m_usp;
      19: return m_isp;
      20: return m_fpst;
      21: return m_bkpc;
      22: return m_bkst;
      23: return m_vbase;
      24: return m_fvec;
      25: return m_acc[63:32];
      26: return m_acc[47:16];
      27: return m_acc[31:0];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void m_wr(int i, logic [31:0] v);
    if (i >= 1 && i <= 15) m_gpr[i] = v;
    case (i)
      0:  if (m_stat[17]) m_usp = v; else m_isp = v;
      16: m_stat  = v;
      17: m_pc    = v;
      18: m_usp   = v;
      19: m_isp   = v;
      20: m_fpst  = fp_model(m_fpst, v);
      21: m_bkpc  = v;
      22: m_bkst  = v;
      23: m_vbase = v;
      24: m_fvec  = v;
      25: m_acc   = {v, m_acc[31:0]};
      26: m_acc   = {m_acc[63:48], v, m_acc[15:0]};
      27: m_acc   = {m_acc[63:32], v};
      default: ;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (i == 0)             return "R3 sp-alias";
    if (i <= 15)            return "R2 gpr";
    if (i == 20)            return "R9 fpst";
    if (i == 25)            return "R5 acc-hi";
    if (i == 26)            return "R6 acc-mid";
    if (i == 27)            return "R7 acc-lo";
    if (i <= LAST_LEGAL)    return "R4 ctrl";
    return "R12 illegal";
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic write_reg(int i, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    m_wr(i, v);
  endtask

  task automatic read_chk(int i, string tag);
    @(negedge clk);
    rd_idx = 6'(i);
    #1;
    chk(tag, 64'(rd_data), 64'(exp_rd(i)));
    chk({tag, " illegal-strobe"}, 64'(rd_illegal), 64'(i > LAST_LEGAL));
  endtask

  task automatic acc_write(logic [63:0] v);
    @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_data = v;
    @(negedge clk);
    acc_wr_en = 1'b0;
    m_acc = v;
  endtask

  task automatic raise_cause(logic [5:0] s);
    @(negedge clk);
    fp_cause_set = s;
    @(negedge clk);
    fp_cause_set = '0;
    m_fpst = m_fpst | (32'(s) << 2);
  endtask

  task automatic bypass(int wi, logic [31:0] v, int ri, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(wi); wr_data = v; rd_idx = 6'(ri);
    m_wr(wi, v);
    #1;
    chk(tag, 64'(rd_data), 64'(exp_rd(ri)));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sweep_all(string tag);
    for (int i = 0; i < N_IDX; i++) read_chk(i, {tag, " ", tag_of(i)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 15; i++) m_gpr[i] = '0;
    m_stat = '0; m_pc = '0; m_usp = '0; m_isp = '0; m_fpst = '0;
    m_bkpc = '0; m_bkst = '0; m_vbase = '0; m_fvec = '0; m_acc = '0;

    // pollute state before reset is seen, then reset (R1)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    write_reg(5, 32'hDEAD_BEEF);
    acc_write(64'hFFFF_0000_FFFF_0000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 1; i <= 15; i++) m_gpr[i] = '0;
    m_acc = '0;
    sweep_all("R1 reset");
    chk("R1 acc port after reset", acc_rd_data, 64'h0);
    chk("R1 round_mode after reset", 64'(round_mode), 64'h0);
    chk("R1 user_mode after reset", 64'(user_mode), 64'h0);

    // write sweep over every legal index, two patterns (R2 R3 R4 R5 R6 R7 R9)
    for (int pat = 0; pat < 2; pat++) begin
      for (int i = 0; i <= LAST_LEGAL; i++) begin
        logic [31:0] v;
        v = (pat == 0 ? 32'hC3A5_1E69 : 32'h5A3C_F0F0) ^ (32'(i) * 32'h0101_0111);
        write_reg(i, v);
        read_chk(i, tag_of(i));
      end
      sweep_all("sweep");
      chk("R3 user_mode follows status", 64'(user_mode), 64'(m_stat[17]));
    end

    // stack pointer steering (R3)
    write_reg(16, 32'h0);
    write_reg(0, 32'h0000_1111);
    read_chk(19, "R3 kernel sp via alias");
    read_chk(0, "R3 alias in kernel mode");
    chk("R3 user_mode low", 64'(user_mode), 64'h0);
    write_reg(16, 32'h0002_0000);
    write_reg(0, 32'h0000_2222);
    read_chk(18, "R3 user sp via alias");
    read_chk(19, "R3 kernel sp untouched");
    read_chk(0, "R3 alias in user mode");
    chk("R3 user_mode high", 64'(user_mode), 64'h1);

    // accumulator windows and full port (R5 R6 R7 R8)
    acc_write(64'h0123_4567_89AB_CDEF);
    chk("R8 full write", acc_rd_data, 64'h0123_4567_89AB_CDEF);
    write_reg(25, 32'hAAAA_BBBB);
    chk("R5 hi window", acc_rd_data, 64'hAAAA_BBBB_89AB_CDEF);
    write_reg(26, 32'h1122_3344);
    chk("R6 mid window", acc_rd_data, 64'hAAAA_1122_3344_CDEF);
    write_reg(27, 32'h5566_7788);
    chk("R7 lo window", acc_rd_data, 64'hAAAA_1122_5566_7788);
    read_chk(26, "R6 mid window read");
    @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_data = 64'hFEDC_BA98_7654_3210;
    wr_en = 1'b1; wr_idx = 6'd27; wr_data = 32'h0BAD_0BAD;
    @(negedge clk);
    acc_wr_en = 1'b0; wr_en = 1'b0;
    m_acc = 64'hFEDC_BA98_7654_3210;
    chk("R8 full port beats window", acc_rd_data, 64'hFEDC_BA98_7654_3210);

    // FP status sweep (R9 R10 R11)
    for (int k = 0; k < 32; k++) begin
      logic [31:0] v;
      raise_cause(6'h3F);
      read_chk(20, "R9 cause raised by hardware");
      v = (32'(k) << 8) | (k[0] ? 32'h8000_0000 : 32'h0) |
          (32'((k * 5) & 63) << 2) | 32'(k & 3) | (32'(k) << 20);
      write_reg(20, v);
      read_chk(20, "R9 R10 fpst write");
      chk("R10 summary bit", 64'(m_fpst[31]), 64'(k != 0));
      chk("R11 round_mode", 64'(round_mode), 64'(k & 3));
    end
    write_reg(20, 32'h0000_0000);
    write_reg(20, 32'h0000_00FC);
    read_chk(20, "R9 write cannot set cleared cause");

    // same-cycle bypass (R13)
    bypass(7, 32'h7777_0007, 7, "R13 gpr bypass");
    bypass(26, 32'hCAFE_F00D, 25, "R13 acc window bypass");
    bypass(20, 32'h0000_1F03, 20, "R13 fpst bypass");
    bypass(16, 32'h0, 0, "R13 alias follows same-cycle status");
    bypass(22, 32'h1357_9BDF, 22, "R13 ctrl bypass");
    @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_data = 64'h0F0F_0F0F_F0F0_F0F0;
    #1;
    chk("R13 acc port bypass", acc_rd_data, 64'h0F0F_0F0F_F0F0_F0F0);
    @(negedge clk);
    acc_wr_en = 1'b0;
    m_acc = 64'h0F0F_0F0F_F0F0_F0F0;

    // writes to illegal indices change nothing (R12)
    for (int i = LAST_LEGAL + 1; i < N_IDX; i += 9) write_reg(i, 32'hFFFF_FFFF);
    write_reg(N_IDX - 1, 32'hFFFF_FFFF);
    sweep_all("R12 after illegal writes");
    chk("R12 acc untouched", acc_rd_data, m_acc);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule